// File: doc/BRIEF.md
# Refresh Row Counter Self-Test Sequencer

This block is a built-in test engine for a multiplexed-address DRAM that carries its own refresh row counter. The counter is normally advanced by refresh cycles in which the column strobe falls before the row strobe. The sequencer checks that this counter visits every row exactly once per wrap. It issues a stream of abstract commands to an access engine or memory model that owns the strobe timing. The commands are refresh cycles, plain writes, plain reads, and counter-test read-modify-write cycles. In a counter-test cycle the device takes the row from its internal counter and the sequencer supplies only the column.

After a start request the sequencer first warms the device up with a fixed number of refresh cycles. It then runs a five-phase pattern twice, once on an all-zero background and once on an all-one background:
- fill every cell with the background;
- at one chosen column, step the counter through every row, reading the background and writing its complement;
- read the complement back row by row;
- step the counter again, reading the complement and restoring the background;
- read the background back.

A skipped or repeated counter value shows up as a data mismatch. On the first mismatch the sequencer stops and reports where it failed.

Top module: `refcnt_selftest`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, passOk, cmdValid, failPhase, failPass and failIndex are all 0.
- R2: A command is held on cmdKind, cmdRow, cmdCol and cmdWdata, with cmdValid high, until cmdAck is seen at a clock edge. Each acknowledged command is counted once, and the next command follows it.
- R3: After an accepted start, the first INIT_CYCLES commands are refresh commands (cmdKind code 0).
- R4: The fill phase issues one write (code 1) per cell with cmdWdata equal to the background. The row advances fastest and the column slowest, both counting up from 0.
- R5: Counter-step phase up (phase code 2) issues 2^ROW_W counter-test commands (code 3) at the latched column, each writing the complement of the background. It expects to read the background.
- R6: Verify phase one (phase code 3) reads (code 2) rows 0 upward at the latched column and expects the complement.
- R7: Counter-step phase down (code 4) issues 2^ROW_W counter-test commands writing the background and expecting the complement. Verify phase two (code 5) reads every row back and expects the background.
- R8: The phase sequence runs first with an all-zero background (failPass 0) and then with an all-one background (failPass 1). The refresh warm-up is not repeated. A clean run is INIT_CYCLES + 2·(2^(ROW_W+COL_W) + 4·2^ROW_W) commands long.
- R9: A run with no mismatch ends with done=1, passOk=1, busy=0 and failPhase=0.
- R10: On the first response that differs from the expected data, the sequencer stops issuing commands. It sets done=1 and passOk=0, and reports failPhase (2 to 5), failPass, and failIndex, the zero-based position of the failing command within its phase.
- R11: A start request while busy is ignored. A start request when idle or done begins a fresh run and clears the previous result.
- R12: The column on testCol is latched at start. Later changes to testCol do not affect the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test run (one-cycle pulse) |
| testCol | input | COL_W | Column under test, latched at start |
| busy | output | 1 | Test run in progress |
| done | output | 1 | Run finished (pass or fail), held until next start |
| passOk | output | 1 | Run finished with no mismatch |
| failPhase | output | 3 | Phase code of the first mismatch, 0 if none |
| failPass | output | 1 | Background pass of the first mismatch (0 zeros, 1 ones) |
| failIndex | output | ROW_W | Command position within the failing phase |
| cmdValid | output | 1 | Command request to the access engine |
| cmdKind | output | 2 | 0 refresh, 1 write, 2 read, 3 counter-test read-modify-write |
| cmdRow | output | ROW_W | Row for write and read commands |
| cmdCol | output | COL_W | Column for write, read and counter-test commands |
| cmdWdata | output | DATA_W | Write data for write and counter-test commands |
| cmdAck | input | 1 | Command completed; rspData valid for read and counter-test |
| rspData | input | DATA_W | Data read by the acknowledged command |

## Verification
The case hardest to reach from the ports is a genuine counter fault: the device's own row counter stalls once, so a row is revisited and another is skipped. The sequencer never sees a row address, so only data betrays the fault. The bench's memory model keeps a private counter with a random starting value and can be told to skip one increment. The expected failure lands one command after the stall, in the counter-step phase. Single-response data corruptions at random and at the pass and phase boundaries pin down the failure coordinates.

// File: rtl/refcnt_selftest_pkg.sv
package refcnt_selftest_pkg;

  typedef enum logic [1:0] {
    K_REFRESH = 2'd0,
    K_WRITE   = 2'd1,
    K_READ    = 2'd2,
    K_CTEST   = 2'd3
  } cmdKind_e;

  typedef enum logic [2:0] {
    PH_WARM  = 3'd0,
    PH_FILL  = 3'd1,
    PH_UP    = 3'd2,
    PH_VER1  = 3'd3,
    PH_DOWN  = 3'd4,
    PH_VER2  = 3'd5
  } phase_e;

  // control to datapath strobes
  typedef struct packed {
    logic   clrAll;   // accepted start: clear results, latch column
    logic   clrIdx;   // phase finished: restart position counter
    logic   stepIdx;  // advance position counter
    logic   capFail;  // record failure coordinates
    phase_e phase;
    logic   passSel;  // 0 zero background, 1 ones background
  } dpCtl_t;

endpackage

// File: rtl/refcnt_selftest_ctrl.sv
module refcnt_selftest_ctrl
  import refcnt_selftest_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   cmdAck,
  input  logic   idxLast,
  input  logic   mismatch,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done,
  output logic   passOk,
  output logic   cmdValid
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE, S_FAIL} state_e;

  state_e stateQ;
  phase_e phaseQ;
  logic   passQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      phaseQ <= PH_WARM;
      passQ  <= 1'b0;
    end else begin
      case (stateQ)
        S_RUN: begin
          if (cmdAck) begin
            if (mismatch) begin
              stateQ <= S_FAIL;
            end else if (idxLast) begin
              case (phaseQ)
                PH_WARM: phaseQ <= PH_FILL;
                PH_FILL: phaseQ <= PH_UP;
                PH_UP:   phaseQ <= PH_VER1;
                PH_VER1: phaseQ <= PH_DOWN;
                PH_DOWN: phaseQ <= PH_VER2;
                default: begin
                  if (!passQ) begin
                    passQ  <= 1'b1;
                    phaseQ <= PH_FILL;
                  end else begin
                    stateQ <= S_DONE;
                  end
                end
              endcase
            end
          end
        end
        default: begin
          if (start) begin
            stateQ <= S_RUN;
            phaseQ <= PH_WARM;
            passQ  <= 1'b0;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.phase   = phaseQ;
    ctl.passSel = passQ;
    if (stateQ != S_RUN && start) ctl.clrAll = 1'b1;
    if (stateQ == S_RUN && cmdAck) begin
      if (mismatch)     ctl.capFail = 1'b1;
      else if (idxLast) ctl.clrIdx  = 1'b1;
      else              ctl.stepIdx = 1'b1;
    end
  end

  assign busy     = (stateQ == S_RUN);
  assign cmdValid = (stateQ == S_RUN);
  assign done     = (stateQ == S_DONE) || (stateQ == S_FAIL);
  assign passOk   = (stateQ == S_DONE);

endmodule

// File: rtl/refcnt_selftest_dp.sv
module refcnt_selftest_dp
  import refcnt_selftest_pkg::*;
#(
  parameter int ROW_W       = 9,
  parameter int COL_W       = 9,
  parameter int DATA_W      = 4,
  parameter int INIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [COL_W-1:0]  testCol,
  input  logic [DATA_W-1:0] rspData,
  output logic              idxLast,
  output logic              mismatch,
  output logic [1:0]        cmdKind,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic [DATA_W-1:0] cmdWdata,
  output logic [2:0]        failPhase,
  output logic              failPass,
  output logic [ROW_W-1:0]  failIndex
);

  localparam int CELL_W = ROW_W + COL_W;
  localparam logic [CELL_W-1:0] LIM_WARM = CELL_W'(INIT_CYCLES - 1);
  localparam logic [CELL_W-1:0] LIM_FILL = {CELL_W{1'b1}};
  localparam logic [CELL_W-1:0] LIM_ROWS = CELL_W'((2 ** ROW_W) - 1);

  logic [CELL_W-1:0] idxQ;
  logic [CELL_W-1:0] limit;
  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] bg;
  logic [DATA_W-1:0] expData;
  logic [DATA_W-1:0] diffBits;
  logic              checkPhase;
  cmdKind_e          kind;

  assign bg = {DATA_W{ctl.passSel}};

  always_comb begin
    kind       = K_REFRESH;
    cmdRow     = '0;
    cmdCol     = '0;
    cmdWdata   = '0;
    expData    = '0;
    checkPhase = 1'b0;
    limit      = LIM_ROWS;
    case (ctl.phase)
      PH_WARM: begin
        limit = LIM_WARM;
      end
      PH_FILL: begin
        kind     = K_WRITE;
        cmdRow   = idxQ[ROW_W-1:0];
        cmdCol   = idxQ[CELL_W-1:ROW_W];
        cmdWdata = bg;
        limit    = LIM_FILL;
      end
      PH_UP: begin
        kind       = K_CTEST;
        cmdCol     = colQ;
        cmdWdata   = ~bg;
        expData    = bg;
        checkPhase = 1'b1;
      end
      PH_VER1: begin
        kind       = K_READ;
        cmdRow     = idxQ[ROW_W-1:0];
        cmdCol     = colQ;
        expData    = ~bg;
        checkPhase = 1'b1;
      end
      PH_DOWN: begin
        kind       = K_CTEST;
        cmdCol     = colQ;
        cmdWdata   = bg;
        expData    = ~bg;
        checkPhase = 1'b1;
      end
      PH_VER2: begin
        kind       = K_READ;
        cmdRow     = idxQ[ROW_W-1:0];
        cmdCol     = colQ;
        expData    = bg;
        checkPhase = 1'b1;
      end
      default: ;
    endcase
  end

  assign cmdKind = kind;
  assign idxLast = (idxQ == limit);

  // per-bit compare of returned data against the pattern
  for (genvar b = 0; b < DATA_W; b++) begin : g_cmp
    assign diffBits[b] = rspData[b] ^ expData[b];
  end
  assign mismatch = checkPhase && (|diffBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ      <= '0;
      colQ      <= '0;
      failPhase <= '0;
      failPass  <= 1'b0;
      failIndex <= '0;
    end else begin
      if (ctl.clrAll) begin
        idxQ      <= '0;
        colQ      <= testCol;
        failPhase <= '0;
        failPass  <= 1'b0;
        failIndex <= '0;
      end else if (ctl.capFail) begin
        failPhase <= ctl.phase;
        failPass  <= ctl.passSel;
        failIndex <= idxQ[ROW_W-1:0];
      end else if (ctl.clrIdx) begin
        idxQ <= '0;
      end else if (ctl.stepIdx) begin
        idxQ <= idxQ + 1'b1;
      end
    end
  end

endmodule

// File: rtl/refcnt_selftest.sv
module refcnt_selftest
  import refcnt_selftest_pkg::*;
#(
  parameter int ROW_W       = 9,
  parameter int COL_W       = 9,
  parameter int DATA_W      = 4,
  parameter int INIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [COL_W-1:0]  testCol,
  output logic              busy,
  output logic              done,
  output logic              passOk,
  output logic [2:0]        failPhase,
  output logic              failPass,
  output logic [ROW_W-1:0]  failIndex,
  output logic              cmdValid,
  output logic [1:0]        cmdKind,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic [DATA_W-1:0] cmdWdata,
  input  logic              cmdAck,
  input  logic [DATA_W-1:0] rspData
);

  dpCtl_t ctl;
  logic   idxLast;
  logic   mismatch;

  refcnt_selftest_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmdAck   (cmdAck),
    .idxLast  (idxLast),
    .mismatch (mismatch),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .passOk   (passOk),
    .cmdValid (cmdValid)
  );

  refcnt_selftest_dp #(
    .ROW_W       (ROW_W),
    .COL_W       (COL_W),
    .DATA_W      (DATA_W),
    .INIT_CYCLES (INIT_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .testCol   (testCol),
    .rspData   (rspData),
    .idxLast   (idxLast),
    .mismatch  (mismatch),
    .cmdKind   (cmdKind),
    .cmdRow    (cmdRow),
    .cmdCol    (cmdCol),
    .cmdWdata  (cmdWdata),
    .failPhase (failPhase),
    .failPass  (failPass),
    .failIndex (failIndex)
  );

endmodule

// File: rtl/refcnt_selftest_chk.sv
module refcnt_selftest_chk #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              passOk,
  input logic [2:0]        failPhase,
  input logic              cmdValid,
  input logic              cmdAck,
  input logic [1:0]        cmdKind,
  input logic [ROW_W-1:0]  cmdRow,
  input logic [COL_W-1:0]  cmdCol,
  input logic [DATA_W-1:0] cmdWdata
);

  // R2
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdAck) |=> (cmdValid && $stable(cmdKind) && $stable(cmdRow)
                               && $stable(cmdCol) && $stable(cmdWdata)));

  // R9
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    passOk |-> (done && !busy && failPhase == 3'd0));

  // R10
  fail_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !passOk) |-> (failPhase >= 3'd2 && failPhase <= 3'd5));

  // R10
  halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cmdValid);

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !cmdAck) |=> busy);

  // R12
  col_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind[1] && $past(cmdValid) && $past(cmdKind[1]))
      |-> (cmdCol == $past(cmdCol)));

endmodule

bind refcnt_selftest refcnt_selftest_chk #(
  .ROW_W  (ROW_W),
  .COL_W  (COL_W),
  .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/tb_refcnt_selftest.sv
module tb_refcnt_selftest;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W    = 4;
  localparam int COL_W    = 2;
  localparam int DATA_W   = 4;
  localparam int INIT_CYC = 8;
  localparam int NR       = 1 << ROW_W;
  localparam int NC       = 1 << COL_W;
  localparam int CELLS    = NR * NC;
  localparam int PER_PASS = CELLS + 4 * NR;
  localparam int TOTAL    = INIT_CYC + 2 * PER_PASS;
  localparam int DMASK    = (1 << DATA_W) - 1;

  logic              clk;
  logic              rstN;
  logic              start;
  logic [COL_W-1:0]  testCol;
  logic              busy, done, passOk, failPass, cmdValid, cmdAck;
  logic [2:0]        failPhase;
  logic [ROW_W-1:0]  failIndex, cmdRow;
  logic [1:0]        cmdKind;
  logic [COL_W-1:0]  cmdCol;
  logic [DATA_W-1:0] cmdWdata, rspData;

  refcnt_selftest #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .INIT_CYCLES(INIT_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .testCol(testCol),
    .busy(busy), .done(done), .passOk(passOk), .failPhase(failPhase),
    .failPass(failPass), .failIndex(failIndex), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .cmdRow(cmdRow), .cmdCol(cmdCol), .cmdWdata(cmdWdata),
    .cmdAck(cmdAck), .rspData(rspData)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int nTests = 0;
  int nFails = 0;

  // memory model state
  logic [DATA_W-1:0] mem [CELLS];
  int refCnt, cmdCount, dataCount, ctestCount, seqErr;
  int faultAt, stuckAt, waitCnt, curCol;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected n-th command from the requirements (R3..R8)
  function automatic void expCmd(input int n, input int col, output int kind,
                                 output int row, output int colE, output int wd,
                                 output bit rowCare, output bit colCare,
                                 output bit wdCare);
    int m, p, k, j, ph, bg;
    kind = 0; row = 0; colE = 0; wd = 0;
    rowCare = 0; colCare = 0; wdCare = 0;
    if (n < INIT_CYC) return;
    m  = n - INIT_CYC;
    p  = m / PER_PASS;
    k  = m % PER_PASS;
    bg = (p != 0) ? DMASK : 0;
    colCare = 1;
    if (k < CELLS) begin
      kind = 1; row = k % NR; colE = k / NR; wd = bg; rowCare = 1; wdCare = 1;
    end else begin
      j    = k - CELLS;
      ph   = 2 + j / NR;
      colE = col;
      if (ph == 2 || ph == 4) begin
        kind = 3; wdCare = 1;
        wd = (ph == 2) ? (~bg & DMASK) : bg;
      end else begin
        kind = 2; row = j % NR; rowCare = 1;
      end
    end
  endfunction

  task automatic flipMaybe();
    if (dataCount == faultAt) rspData[0] = ~rspData[0];
    dataCount++;
  endtask

  task automatic serve();
    int kind, row, colE, wd, addr;
    bit rowCare, colCare, wdCare;
    expCmd(cmdCount, curCol, kind, row, colE, wd, rowCare, colCare, wdCare);
    if (int'(cmdKind) != kind || (rowCare && int'(cmdRow) != row) ||
        (colCare && int'(cmdCol) != colE) || (wdCare && int'(cmdWdata) != wd)) begin
      if (seqErr == 0)
        $display("  command %0d: kind %0d row %0d col %0d data %0d, wanted kind %0d row %0d col %0d data %0d",
                 cmdCount, cmdKind, cmdRow, cmdCol, cmdWdata, kind, row, colE, wd);
      seqErr++;
    end
    case (cmdKind)
      2'd0: refCnt = (refCnt + 1) % NR;
      2'd1: mem[int'(cmdCol) * NR + int'(cmdRow)] = cmdWdata;
      2'd2: begin
        rspData = mem[int'(cmdCol) * NR + int'(cmdRow)];
        flipMaybe();
      end
      default: begin
        addr = int'(cmdCol) * NR + refCnt;
        rspData = mem[addr];
        mem[addr] = cmdWdata;
        if (ctestCount != stuckAt) refCnt = (refCnt + 1) % NR;
        ctestCount++;
        flipMaybe();
      end
    endcase
    cmdCount++;
  endtask

  // access engine model: answers at negedges with random latency
  initial begin
    cmdAck  = 1'b0;
    rspData = '0;
    waitCnt = 0;
    forever begin
      @(negedge clk);
      if (cmdAck) cmdAck = 1'b0;
      else if (rstN && cmdValid) begin
        if (waitCnt > 0) waitCnt--;
        else begin
          serve();
          cmdAck  = 1'b1;
          waitCnt = $urandom % 3;
        end
      end
    end
  end

  task automatic runTest(input int col, input int faultN, input int stuck,
                         input bit expOk, input int ePh, input int ePass,
                         input int eIdx, input int eCount, input bit disturb,
                         input string tag);
    cmdCount = 0; dataCount = 0; ctestCount = 0; seqErr = 0;
    faultAt = faultN; stuckAt = stuck; curCol = col;
    refCnt = $urandom % NR;
    for (int i = 0; i < CELLS; i++) mem[i] = DATA_W'($urandom);
    @(negedge clk);
    testCol = COL_W'(col);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R11", {tag, " start accepted"}, busy, 1);
    if (disturb) begin
      repeat (40) @(negedge clk);
      testCol = ~COL_W'(col);
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      check(busy == 1'b1 && done == 1'b0, "R11", {tag, " start while busy ignored"}, busy, 1);
    end
    while (!done) @(negedge clk);
    check(seqErr == 0, "R2 R3 R4 R5 R6 R7 R12", {tag, " command sequence errors"}, seqErr, 0);
    if (expOk) begin
      check(passOk == 1'b1 && busy == 1'b0, "R9", {tag, " passOk"}, passOk, 1);
      check(failPhase == 3'd0, "R9", {tag, " failPhase"}, failPhase, 0);
      check(cmdCount == TOTAL, "R8", {tag, " command count"}, cmdCount, TOTAL);
    end else begin
      check(passOk == 1'b0, "R10", {tag, " passOk"}, passOk, 0);
      check(int'(failPhase) == ePh, "R10", {tag, " failPhase"}, failPhase, ePh);
      check(int'(failPass) == ePass, "R10 R8", {tag, " failPass"}, failPass, ePass);
      check(int'(failIndex) == eIdx, "R10", {tag, " failIndex"}, failIndex, eIdx);
      check(cmdCount == eCount, "R10", {tag, " commands until stop"}, cmdCount, eCount);
    end
    repeat (8) @(negedge clk);
    check(cmdValid == 1'b0 && done == 1'b1 && cmdCount == eCount, "R10",
          {tag, " quiet after end"}, cmdCount, eCount);
    testCol = COL_W'(col);
  endtask

  // data fault at the n-th data response
  task automatic faultRun(input int col, input int n, input string tag);
    int p, j;
    p = n / (4 * NR);
    j = n % (4 * NR);
    runTest(col, n, -1, 1'b0, 2 + j / NR, p, j % NR,
            INIT_CYC + p * PER_PASS + CELLS + j + 1, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; start = 1'b0; testCol = '0;
    faultAt = -1; stuckAt = -1; curCol = 0;
    repeat (3) @(negedge clk);
    check({busy, done, passOk, cmdValid} == 4'b0 && failPhase == 3'd0 &&
          failPass == 1'b0 && failIndex == '0, "R1", "outputs in reset", busy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, passOk, cmdValid} == 4'b0 && failPhase == 3'd0,
          "R1", "outputs after reset", done, 0);

    // clean runs, one with a start and a column change mid-run
    runTest(3, -1, -1, 1'b1, 0, 0, 0, TOTAL, 1'b1, "clean col3 disturbed");
    runTest(0, -1, -1, 1'b1, 0, 0, 0, TOTAL, 1'b0, "clean col0");

    // directed data faults at phase and pass boundaries
    faultRun(1, 0, "fault first counter step");
    faultRun(2, 4 * NR - 1, "fault last read of pass 0");
    faultRun(2, 4 * NR, "fault first step of pass 1");
    faultRun(0, 8 * NR - 1, "fault final read");

    // counter stalls once: row revisited on the next step
    runTest(1, -1, 5, 1'b0, 2, 0, 6, INIT_CYC + CELLS + 7, 1'b0, "stalled counter");

    // random data faults
    for (int t = 0; t < 5; t++) begin
      faultRun($urandom % NC, $urandom % (8 * NR), "random fault");
    end

    // restart after failure clears result
    runTest(2, -1, -1, 1'b1, 0, 0, 0, TOTAL, 1'b0, "R11 rerun after fail");

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule